// File: doc/BRIEF.md
# Shared Registry Cache Controller

This block is the shared last-level cache bank that also serves as the coherence registry for a group of private caches. Each word of a cached line is in one of three conditions. It may be absent because the line is not present. It may be Valid, in which case the slot holds the current data. It may be Registered, in which case the slot holds the id of the private cache that owns the up-to-date copy. A slot never holds both. No sharer lists are kept anywhere.

Private caches send three kinds of request:
- A read: it returns the data, or is forwarded to the owner.
- A registration: a core announces that it now holds the latest copy of a word.
- A writeback: it returns ownership together with the data.

A miss first obtains the whole line from memory, after writing back a dirty victim. Requests are handled strictly one at a time. A new request is accepted only while `reqReady` is high. Each request ends with at most one response pulse.

The cache is direct-mapped. The word address divides into three fields, from low to high:
- word offset, bits [1:0] by default;
- line index, bits [4:2];
- tag, bits [7:5].

Memory is addressed by line address {tag, index}.

Top module: `registry_cache`

## Requirements
- R1: After reset `reqReady` is 1, and `rspValid` and `memReqValid` are 0. The first access to any address misses.
- R2: A read or registration (`reqKind` 0 or 1) that misses on a clean or empty line issues exactly one memory read with `memReqWrite`=0. Its `memReqLine` is the request's {tag,index}. All words of the line are then installed as Valid, and the request is then served as a hit; for a read this returns `rspKind` 0 with the filled word.
- R3: A read (`reqKind` 0) to a Valid word returns `rspKind` 0 (data) to the requester, with `rspDest`=`rspSrc`=`reqCore`, `rspAddr`=`reqAddr` and `rspData` the word. It causes no memory traffic.
- R4: A read to a word Registered to core j returns `rspKind` 2 (forwarded read), with `rspDest`=j, `rspSrc` set to the requester, `rspAddr` set to the address and `rspData`=0. The word is left unchanged.
- R5: A registration (`reqKind` 1) to a Valid word makes it Registered to the requester and answers `rspKind` 1 (acknowledge) to the requester. This includes a word just filled after a miss.
- R6: A registration to a word Registered to core j answers `rspKind` 3 (forwarded registration), with `rspDest`=j and `rspSrc` set to the requester. The stored owner becomes the requester, so later reads are forwarded to the new owner.
- R7: A writeback (`reqKind` 2) from the current registrant of a present word is acknowledged with `rspKind` 4 to that core. The word becomes Valid holding `reqData`, and the line becomes dirty.
- R8: Some writebacks are ignored: one from a core that is not the registrant, one to a Valid word, and one to a line that is not present. Such a writeback gives no response, changes no stored state and causes no memory traffic.
- R9: While a fill is outstanding, a memory response whose `memRspLine` differs from the requested line is ignored. Only a matching response installs the data.
- R10: A miss that evicts a dirty line first issues a memory write, and then, on the next cycle, the memory read. The write carries the victim's line address and its words, with `memReqMask` bit w set only for words that are Valid. Registered words are not written.
- R11: `reqReady` falls in the cycle after a request is accepted and stays low until the request completes. The response, if any, is a single-cycle pulse in the same cycle that `reqReady` returns high.
- R12: Request kind 3 is reserved. It completes with no response, no memory traffic and no change of stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle; request accepted on this edge |
| reqKind | input | 2 | 0 read, 1 registration, 2 writeback, 3 reserved |
| reqCore | input | CORE_W (6) | Requesting core id |
| reqAddr | input | ADDR_W (8) | Word address |
| reqData | input | DATA_W (32) | Writeback data |
| rspValid | output | 1 | Response pulse |
| rspKind | output | 3 | 0 data, 1 registration ack, 2 forwarded read, 3 forwarded registration, 4 writeback ack |
| rspDest | output | CORE_W (6) | Core that receives the response |
| rspSrc | output | CORE_W (6) | Original requester |
| rspAddr | output | ADDR_W (8) | Word address of the request |
| rspData | output | DATA_W (32) | Data for kind 0, else zero |
| memReqValid | output | 1 | Memory request pulse |
| memReqWrite | output | 1 | 1 write of victim, 0 line read |
| memReqLine | output | ADDR_W-log2(WORDS) (6) | Line address {tag,index} |
| memReqMask | output | WORDS (4) | Word-write mask for victim writes |
| memReqData | output | WORDS*DATA_W (128) | Victim line, word w in bits [w*DATA_W +: DATA_W] |
| memRspValid | input | 1 | Memory fill data present |
| memRspLine | input | ADDR_W-log2(WORDS) (6) | Line address of fill data |
| memRspData | input | WORDS*DATA_W (128) | Fill line, same word layout |

## Verification
The assertions rely on two properties of the environment. Memory must accept every request at once, and it must eventually answer each line read. The requesters must present a request only as a single transaction, which is taken while the controller is idle. The bench memory keeps to this. It absorbs writes immediately and answers each read a few cycles later, sometimes sending a response for the wrong line first. Requests are issued one after another, each after the previous one has completed. Random addresses are confined to three tags, so that hits, evictions of dirty lines and partly registered lines all occur. Writebacks are drawn both from the true owner and from other cores.

// File: rtl/regcache_pkg.sv
package regcache_pkg;
  typedef enum logic [1:0] {
    REQ_READ      = 2'd0,
    REQ_REGISTER  = 2'd1,
    REQ_WRITEBACK = 2'd2,
    REQ_RESERVED  = 2'd3
  } reqKind_e;

  typedef enum logic [2:0] {
    RSP_DATA     = 3'd0,
    RSP_REG_ACK  = 3'd1,
    RSP_FWD_READ = 3'd2,
    RSP_FWD_REG  = 3'd3,
    RSP_WB_ACK   = 3'd4
  } rspKind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_RDREQ,
    ST_WAIT
  } ctrlState_e;

  typedef struct packed {
    logic latchReq;
    logic doAction;
    logic memRead;
    logic memWrite;
    logic install;
  } ctrlStrobe_t;
endpackage

// File: rtl/regcache_ctrl.sv
module regcache_ctrl
  import regcache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hit,
  input  logic        passThrough,
  input  logic        victimDirty,
  input  logic        memRspValid,
  input  logic        fillMatch,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);
  ctrlState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext       = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (hit || passThrough) begin
          strobe.doAction = 1'b1;
          stateNext       = ST_IDLE;
        end else if (victimDirty) begin
          strobe.memWrite = 1'b1;
          stateNext       = ST_RDREQ;
        end else begin
          strobe.memRead = 1'b1;
          stateNext      = ST_WAIT;
        end
      end
      ST_RDREQ: begin
        strobe.memRead = 1'b1;
        stateNext      = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid && fillMatch) begin
          strobe.install = 1'b1;
          stateNext      = ST_EXEC;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
endmodule

// File: rtl/regcache_dp.sv
module regcache_dp
  import regcache_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CORE_W = 6,
  parameter int ADDR_W = 8,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobe_t                       strobe,
  input  logic [1:0]                        reqKind,
  input  logic [CORE_W-1:0]                 reqCore,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [DATA_W-1:0]                 reqData,
  input  logic [ADDR_W-$clog2(WORDS)-1:0]   memRspLine,
  input  logic [WORDS*DATA_W-1:0]           memRspData,
  output logic                              hit,
  output logic                              passThrough,
  output logic                              victimDirty,
  output logic                              fillMatch,
  output logic                              rspValid,
  output logic [2:0]                        rspKind,
  output logic [CORE_W-1:0]                 rspDest,
  output logic [CORE_W-1:0]                 rspSrc,
  output logic [ADDR_W-1:0]                 rspAddr,
  output logic [DATA_W-1:0]                 rspData,
  output logic                              memReqValid,
  output logic                              memReqWrite,
  output logic [ADDR_W-$clog2(WORDS)-1:0]   memReqLine,
  output logic [WORDS-1:0]                  memReqMask,
  output logic [WORDS*DATA_W-1:0]           memReqData
);
  localparam int OFF_W     = $clog2(WORDS);
  localparam int IDX_W     = $clog2(LINES);
  localparam int LADDR_W   = ADDR_W - OFF_W;
  localparam int TAG_W     = LADDR_W - IDX_W;
  localparam int LINE_BITS = WORDS * DATA_W;

  logic [LINES-1:0]  lineValid, lineDirty;
  logic [TAG_W-1:0]  lineTag [LINES];
  logic [WORDS-1:0]  regBits [LINES];
  logic [DATA_W-1:0] slots   [LINES][WORDS];

  reqKind_e          qKind;
  logic [CORE_W-1:0] qCore;
  logic [ADDR_W-1:0] qAddr;
  logic [DATA_W-1:0] qData;

  logic [OFF_W-1:0]  qOff;
  logic [IDX_W-1:0]  qIdx;
  logic [TAG_W-1:0]  qTag;
  assign qOff = qAddr[OFF_W-1:0];
  assign qIdx = qAddr[OFF_W +: IDX_W];
  assign qTag = qAddr[ADDR_W-1 -: TAG_W];

  logic              wordReg;
  logic [DATA_W-1:0] wordData;
  logic [CORE_W-1:0] owner;
  logic [LINE_BITS-1:0] victimData;

  assign wordReg  = regBits[qIdx][qOff];
  assign wordData = slots[qIdx][qOff];
  assign owner    = wordData[CORE_W-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_pack
    assign victimData[w*DATA_W +: DATA_W] = slots[qIdx][w];
  end

  assign hit         = lineValid[qIdx] && (lineTag[qIdx] == qTag);
  assign passThrough = (qKind == REQ_WRITEBACK) || (qKind == REQ_RESERVED);
  assign victimDirty = lineValid[qIdx] && lineDirty[qIdx];
  assign fillMatch   = (memRspLine == {qTag, qIdx});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid   <= '0;
      lineDirty   <= '0;
      for (int l = 0; l < LINES; l++) regBits[l] <= '0;
      qKind       <= REQ_READ;
      qCore       <= '0;
      qAddr       <= '0;
      qData       <= '0;
      rspValid    <= 1'b0;
      rspKind     <= RSP_DATA;
      rspDest     <= '0;
      rspSrc      <= '0;
      rspAddr     <= '0;
      rspData     <= '0;
      memReqValid <= 1'b0;
      memReqWrite <= 1'b0;
      memReqLine  <= '0;
      memReqMask  <= '0;
      memReqData  <= '0;
    end else begin
      rspValid    <= 1'b0;
      memReqValid <= 1'b0;

      if (strobe.latchReq) begin
        qKind <= reqKind_e'(reqKind);
        qCore <= reqCore;
        qAddr <= reqAddr;
        qData <= reqData;
      end

      if (strobe.memWrite) begin
        memReqValid <= 1'b1;
        memReqWrite <= 1'b1;
        memReqLine  <= {lineTag[qIdx], qIdx};
        memReqMask  <= ~regBits[qIdx];
        memReqData  <= victimData;
      end

      if (strobe.memRead) begin
        memReqValid <= 1'b1;
        memReqWrite <= 1'b0;
        memReqLine  <= {qTag, qIdx};
        memReqMask  <= '0;
      end

      if (strobe.install) begin
        for (int w = 0; w < WORDS; w++) slots[qIdx][w] <= memRspData[w*DATA_W +: DATA_W];
        regBits[qIdx]   <= '0;
        lineValid[qIdx] <= 1'b1;
        lineDirty[qIdx] <= 1'b0;
        lineTag[qIdx]   <= qTag;
      end

      if (strobe.doAction) begin
        rspAddr <= qAddr;
        rspSrc  <= qCore;
        rspDest <= qCore;
        rspData <= '0;
        unique case (qKind)
          REQ_READ: begin
            rspValid <= 1'b1;
            if (wordReg) begin
              rspKind <= RSP_FWD_READ;
              rspDest <= owner;
            end else begin
              rspKind <= RSP_DATA;
              rspData <= wordData;
            end
          end
          REQ_REGISTER: begin
            rspValid           <= 1'b1;
            slots[qIdx][qOff]  <= DATA_W'(qCore);
            if (wordReg) begin
              rspKind <= RSP_FWD_REG;
              rspDest <= owner;
            end else begin
              rspKind              <= RSP_REG_ACK;
              regBits[qIdx][qOff]  <= 1'b1;
            end
          end
          REQ_WRITEBACK: begin
            if (hit && wordReg && (owner == qCore)) begin
              rspValid            <= 1'b1;
              rspKind             <= RSP_WB_ACK;
              slots[qIdx][qOff]   <= qData;
              regBits[qIdx][qOff] <= 1'b0;
              lineDirty[qIdx]     <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/registry_cache.sv
module registry_cache
  import regcache_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CORE_W = 6,
  parameter int ADDR_W = 8,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  output logic                              reqReady,
  input  logic [1:0]                        reqKind,
  input  logic [CORE_W-1:0]                 reqCore,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [DATA_W-1:0]                 reqData,
  output logic                              rspValid,
  output logic [2:0]                        rspKind,
  output logic [CORE_W-1:0]                 rspDest,
  output logic [CORE_W-1:0]                 rspSrc,
  output logic [ADDR_W-1:0]                 rspAddr,
  output logic [DATA_W-1:0]                 rspData,
  output logic                              memReqValid,
  output logic                              memReqWrite,
  output logic [ADDR_W-$clog2(WORDS)-1:0]   memReqLine,
  output logic [WORDS-1:0]                  memReqMask,
  output logic [WORDS*DATA_W-1:0]           memReqData,
  input  logic                              memRspValid,
  input  logic [ADDR_W-$clog2(WORDS)-1:0]   memRspLine,
  input  logic [WORDS*DATA_W-1:0]           memRspData
);
  ctrlStrobe_t strobe;
  logic hit, passThrough, victimDirty, fillMatch;

  regcache_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .hit, .passThrough, .victimDirty,
    .memRspValid, .fillMatch, .reqReady, .strobe
  );

  regcache_dp #(
    .DATA_W(DATA_W), .CORE_W(CORE_W), .ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)
  ) u_dp (
    .clk, .rstN, .strobe, .reqKind, .reqCore, .reqAddr, .reqData,
    .memRspLine, .memRspData, .hit, .passThrough, .victimDirty, .fillMatch,
    .rspValid, .rspKind, .rspDest, .rspSrc, .rspAddr, .rspData,
    .memReqValid, .memReqWrite, .memReqLine, .memReqMask, .memReqData
  );
endmodule

// File: rtl/registry_cache_chk.sv
module registry_cache_chk #(
  parameter int CORE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [2:0]        rspKind,
  input logic [CORE_W-1:0] rspDest,
  input logic [CORE_W-1:0] rspSrc,
  input logic              memReqValid,
  input logic              memReqWrite
);
  p_rsp_at_ready_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

  p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_evict_then_fill_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |=> (memReqValid && !memReqWrite));

  p_mem_while_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (!rspValid && !reqReady));

  p_ack_to_self_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspKind == 3'd0 || rspKind == 3'd1 || rspKind == 3'd4)) |-> (rspDest == rspSrc));

  p_kind_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspKind <= 3'd4));
endmodule

bind registry_cache registry_cache_chk #(.CORE_W(CORE_W)) u_chk (.*);

// File: tb/registry_cache_tb_top.sv
module registry_cache_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic         reqValid = 0, reqReady;
  logic [1:0]   reqKind = 0;
  logic [5:0]   reqCore = 0;
  logic [7:0]   reqAddr = 0;
  logic [31:0]  reqData = 0;
  logic         rspValid;
  logic [2:0]   rspKind;
  logic [5:0]   rspDest, rspSrc;
  logic [7:0]   rspAddr;
  logic [31:0]  rspData;
  logic         memReqValid, memReqWrite;
  logic [5:0]   memReqLine;
  logic [3:0]   memReqMask;
  logic [127:0] memReqData;
  logic         memRspValid = 0;
  logic [5:0]   memRspLine = 0;
  logic [127:0] memRspData = 0;

  registry_cache dut_i (.*);

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  logic [31:0] mem  [256];
  logic [31:0] emem [256];
  bit          mValid [8];
  bit          mDirty [8];
  logic [2:0]  mTag   [8];
  bit          mReg   [8][4];
  logic [31:0] mSlot  [8][4];

  bit eRsp, eWr, eRd;
  logic [2:0]  eKind;
  logic [5:0]  eDest, eWrLine, eRdLine;
  logic [31:0] eData;
  logic [3:0]  eWrMask;
  logic [127:0] eWrData;
  string eTag;

  function automatic logic [31:0] memInit(int a);
    return 32'h5A000000 ^ (a * 32'h00010203);
  endfunction

  task automatic check(string tag, string what, logic [199:0] act, logic [199:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic predict(logic [1:0] k, logic [5:0] c, logic [7:0] a, logic [31:0] d);
    logic [2:0] idx = a[4:2];
    logic [1:0] off = a[1:0];
    logic [2:0] tg  = a[7:5];
    bit hit = mValid[idx] && (mTag[idx] == tg);
    eRsp = 0; eWr = 0; eRd = 0; eKind = 0; eDest = 0; eData = 0;
    eWrLine = 0; eRdLine = 0; eWrMask = 0; eWrData = 0;
    if (k == 2'd3) begin eTag = "R12"; return; end
    if (k == 2'd2) begin
      if (hit && mReg[idx][off] && mSlot[idx][off][5:0] == c) begin
        eRsp = 1; eKind = 3'd4; eDest = c; eTag = "R7";
        mSlot[idx][off] = d; mReg[idx][off] = 0; mDirty[idx] = 1;
      end else eTag = "R8";
      return;
    end
    if (!hit) begin
      if (mValid[idx] && mDirty[idx]) begin
        eWr = 1; eWrLine = {mTag[idx], idx};
        for (int w = 0; w < 4; w++) if (!mReg[idx][w]) begin
          eWrMask[w] = 1'b1;
          eWrData[w*32 +: 32] = mSlot[idx][w];
          emem[{eWrLine, 2'(w)}] = mSlot[idx][w];
        end
      end
      eRd = 1; eRdLine = {tg, idx};
      for (int w = 0; w < 4; w++) begin
        mSlot[idx][w] = emem[{tg, idx, 2'(w)}];
        mReg[idx][w] = 0;
      end
      mValid[idx] = 1; mDirty[idx] = 0; mTag[idx] = tg;
    end
    eRsp = 1;
    if (k == 2'd0) begin
      if (mReg[idx][off]) begin eKind = 3'd2; eDest = mSlot[idx][off][5:0]; eTag = "R4"; end
      else begin eKind = 3'd0; eDest = c; eData = mSlot[idx][off]; eTag = hit ? "R3" : "R2"; end
    end else begin
      if (mReg[idx][off]) begin eKind = 3'd3; eDest = mSlot[idx][off][5:0]; eTag = "R6"; end
      else begin eKind = 3'd1; eDest = c; mReg[idx][off] = 1; eTag = "R5"; end
      mSlot[idx][off] = {26'b0, c};
    end
  endtask

  int oRdCnt;

  task automatic runReq(logic [1:0] k, logic [5:0] c, logic [7:0] a, logic [31:0] d, bit wrongFirst);
    int oRspCnt = 0, oWrCnt = 0, countdown = 0;
    bit done = 0, rspAtReady = 0, wrBefore = 0, wrong = wrongFirst;
    logic [55:0] oRsp = 0, xRsp;
    logic [5:0] oWrLine = 0, oRdLine = 0;
    logic [3:0] oWrMask = 0;
    logic [127:0] oWrData = 0;
    string tag;
    predict(k, c, a, d);
    tag = wrongFirst ? "R9" : eTag;
    oRdCnt = 0;
    @(negedge clk);
    reqValid = 1; reqKind = k; reqCore = c; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 0;
    for (int n = 0; n < 300 && !done; n++) begin
      if (n > 0) @(negedge clk);
      memRspValid = 0;
      if (rspValid) begin
        oRspCnt++; rspAtReady = reqReady;
        oRsp = {1'b1, rspKind, rspDest, rspSrc, rspAddr, rspData};
      end
      if (memReqValid) begin
        if (memReqWrite) begin
          oWrCnt++; oWrLine = memReqLine; oWrMask = memReqMask;
          for (int w = 0; w < 4; w++) if (memReqMask[w]) begin
            oWrData[w*32 +: 32] = memReqData[w*32 +: 32];
            mem[{memReqLine, 2'(w)}] = memReqData[w*32 +: 32];
          end
        end else begin
          oRdCnt++; oRdLine = memReqLine; wrBefore = (oWrCnt > 0); countdown = 3;
        end
      end
      if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin
          memRspValid = 1;
          if (wrong) begin
            memRspLine = oRdLine ^ 6'h01; memRspData = '1; wrong = 0; countdown = 3;
          end else begin
            memRspLine = oRdLine;
            for (int w = 0; w < 4; w++) memRspData[w*32 +: 32] = mem[{oRdLine, 2'(w)}];
          end
        end
      end
      if (reqReady) done = 1;
    end
    memRspValid = 0;
    if (!done) check("R11", "request never completed", 0, 1);
    xRsp = eRsp ? {1'b1, eKind, eDest, c, a, eData} : 56'd0;
    check(tag, "response", oRsp, xRsp);
    check("R11", "single pulse at ready", {oRspCnt <= 1, (oRspCnt == 0) || rspAtReady}, 2'b11);
    check(eWr ? "R10" : tag, "memory write", {4'(oWrCnt), oWrLine, oWrMask, oWrData},
          {4'(eWr), eWrLine, eWrMask, eWrData});
    check(eRd ? "R2" : tag, "memory read", {4'(oRdCnt), oRdLine, wrBefore},
          {4'(eRd), eRdLine, eWr});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 256; i++) begin mem[i] = memInit(i); emem[i] = memInit(i); end
    for (int l = 0; l < 8; l++) begin
      mValid[l] = 0; mDirty[l] = 0; mTag[l] = 0;
      for (int w = 0; w < 4; w++) begin mReg[l][w] = 0; mSlot[l][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", "idle outputs after reset", {reqReady, rspValid, memReqValid}, 3'b100);

    runReq(0, 6'd3, 8'h25, 0, 0);
    check("R1", "first access fills", 32'(oRdCnt), 32'd1);
    runReq(0, 6'd4, 8'h25, 0, 0);             // R3 hit
    runReq(1, 6'd5, 8'h25, 0, 0);             // R5 register Valid word
    runReq(0, 6'd6, 8'h25, 0, 0);             // R4 forward to 5
    runReq(1, 6'd7, 8'h25, 0, 0);             // R6 forward registration, owner -> 7
    runReq(0, 6'd8, 8'h25, 0, 0);             // R6 read now forwarded to 7
    runReq(2, 6'd5, 8'h25, 32'h11112222, 0);  // R8 stale owner ignored
    runReq(0, 6'd8, 8'h25, 0, 0);             // R8 still forwarded to 7
    runReq(2, 6'd7, 8'h25, 32'hDEADBEEF, 0);  // R7 accepted
    runReq(0, 6'd1, 8'h25, 0, 0);             // R7 data now Valid
    runReq(2, 6'd1, 8'h25, 32'h33334444, 0);  // R8 writeback to Valid word
    runReq(2, 6'd2, 8'hE0, 32'h55556666, 0);  // R8 absent line
    runReq(3, 6'd2, 8'h25, 32'h77778888, 0);  // R12 reserved kind
    runReq(0, 6'd2, 8'h25, 0, 0);             // R12 nothing changed
    runReq(1, 6'd9, 8'h26, 0, 0);             // R5 register a second word
    runReq(0, 6'd9, 8'h45, 0, 0);             // R10 dirty victim, masked write
    runReq(0, 6'd9, 8'h25, 0, 0);             // R10 written data came back
    runReq(0, 6'd10, 8'h01, 0, 1);            // R9 wrong line response first

    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 10;
      logic [1:0] k = (sel < 4) ? 2'd0 : (sel < 7) ? 2'd1 : (sel < 9) ? 2'd2 : 2'd3;
      logic [7:0] a = {3'($urandom % 3), 5'($urandom)};
      logic [5:0] c = 6'($urandom);
      if (k == 2'd2 && mValid[a[4:2]] && mTag[a[4:2]] == a[7:5] && mReg[a[4:2]][a[1:0]] && ($urandom % 2))
        c = mSlot[a[4:2]][a[1:0]][5:0];
      runReq(k, c, a, $urandom, ($urandom % 8) == 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule